// File: doc/BRIEF.md
# USB Link Power Management Sleep Tracker

This block keeps the sleep state of a USB device under Link Power Management. When the link layer reports that the device has acknowledged a sleep request, the tracker starts a token-retry wait. Only after that wait ends does it raise the sleep bit. The same acknowledge records whether the host allowed the device to wake the link by itself. A resume started by the host, or a bus reset, ends the sleep state, withdraws the wake permission and cancels any wait still running.

Software leaves sleep by writing zero to the sleep bit. The tracker accepts that write only while the device is asleep and the host has granted remote wake. An accepted write produces a single-cycle wake strobe for the line driver. A global enable decides whether any of this is tracked. While the enable is low, the sleep bit is frozen.

Top module: `lpm_sleep_tracker`

## Requirements
- R1: After reset, `lpm_sus_o`, `wake_grant_o` and `wake_pulse_o` are all 0.
- R2: An acknowledge sampled with `lpm_en_i`=1 at clock edge N raises `lpm_sus_o` at edge N+RETRY_CYCLES, and not earlier.
- R3: A new acknowledge during the wait restarts it, so the sleep bit rises RETRY_CYCLES edges after the newest acknowledge.
- R4: An acknowledge with `lpm_rwake_flag_i`=1 sets `wake_grant_o` on the next edge. An acknowledge with the flag at 0 leaves `wake_grant_o` unchanged.
- R5: `host_resume_i` clears `lpm_sus_o` (while enabled) and `wake_grant_o` on the next edge. It also cancels a pending wait.
- R6: `bus_reset_i` clears `lpm_sus_o` (while enabled) and `wake_grant_o` on the next edge. It also cancels a pending wait.
- R7: `sw_wr_i`=1 with `sw_wdata_i`=0 while `lpm_sus_o`=1, `wake_grant_o`=1 and `lpm_en_i`=1 clears both bits on the next edge. On that same edge, `wake_pulse_o` goes high for exactly one cycle.
- R8: A write of 0 while `wake_grant_o`=0 or `lpm_sus_o`=0 has no effect, and neither does any write of 1.
- R9: While `lpm_en_i`=0, `lpm_sus_o` holds its value through every event, and acknowledges are ignored (no grant, no wait).
- R10: A resume or bus reset in the same cycle as the wait's expiry or an accepted wake write takes priority. The sleep bit stays 0 and no wake strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lpm_en_i | input | 1 | Sleep tracking enabled |
| lpm_ack_i | input | 1 | One-cycle pulse: sleep request acknowledged |
| lpm_rwake_flag_i | input | 1 | Remote-wake flag carried by the acknowledged request |
| host_resume_i | input | 1 | One-cycle pulse: host-initiated resume |
| bus_reset_i | input | 1 | One-cycle pulse: USB bus reset |
| sw_wr_i | input | 1 | Software write strobe to the sleep bit |
| sw_wdata_i | input | 1 | Value written to the sleep bit |
| lpm_sus_o | output | 1 | Sleep state bit |
| wake_grant_o | output | 1 | Host has permitted remote wake |
| wake_pulse_o | output | 1 | One-cycle remote wake-up strobe |

## Verification
Two pairs of events can fall in the same cycle, and each is tested. In the first, the bench places a host resume exactly on the edge where the retry wait would expire, by counting RETRY_CYCLES negative edges from the acknowledge. In the second, it drives a bus reset together with an otherwise valid wake write of zero. The scoreboard expects the resume or reset to win both times: the sleep bit never rises, the grant clears, and no wake strobe appears in the following cycle.

// File: rtl/lpm_sleep_pkg.sv
package lpm_sleep_pkg;
  typedef enum logic {
    TMR_IDLE  = 1'b0,
    TMR_ARMED = 1'b1
  } tmr_state_e;

  typedef struct packed {
    logic ack;   // acknowledge accepted (enable already applied)
    logic kill;  // resume or bus reset
  } lpm_evt_t;
endpackage

// File: rtl/lpm_retry_timer.sv
module lpm_retry_timer
  import lpm_sleep_pkg::*;
#(
  parameter int unsigned RETRY_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic expire_o
);
  localparam int unsigned CW = (RETRY_CYCLES < 2) ? 1 : $clog2(RETRY_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RETRY_CYCLES - 1);

  tmr_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic at_last;

  assign at_last  = (state_q == TMR_ARMED) && (cnt_q == LAST);
  // a restart or a cancel in the final cycle suppresses expiry
  assign expire_o = at_last && !start_i && !cancel_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (cancel_i) begin
      state_d = TMR_IDLE;
      cnt_d   = '0;
    end else if (start_i) begin
      state_d = TMR_ARMED;
      cnt_d   = '0;
    end else if (state_q == TMR_ARMED) begin
      if (at_last) begin
        state_d = TMR_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/lpm_wake_grant.sv
module lpm_wake_grant (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  input  logic rwake_flag_i,
  input  logic clear_i,
  output logic grant_o
);
  logic grant_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    grant_q <= 1'b0;
    else if (clear_i)               grant_q <= 1'b0;
    else if (ack_i && rwake_flag_i) grant_q <= 1'b1;
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/lpm_sus_ctrl.sv
module lpm_sus_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic expire_i,
  input  logic kill_i,
  input  logic sw_wr_i,
  input  logic sw_wdata_i,
  input  logic grant_i,
  output logic sus_o,
  output logic wake_fire_o,
  output logic wake_pulse_o
);
  logic sus_q, pulse_q;

  assign wake_fire_o = en_i && sw_wr_i && !sw_wdata_i && sus_q && grant_i && !kill_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sus_q <= 1'b0;
    end else if (en_i) begin
      if (kill_i || wake_fire_o) sus_q <= 1'b0;
      else if (expire_i)         sus_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= wake_fire_o;
  end

  assign sus_o        = sus_q;
  assign wake_pulse_o = pulse_q;
endmodule

// File: rtl/lpm_sleep_tracker.sv
module lpm_sleep_tracker
  import lpm_sleep_pkg::*;
#(
  parameter int unsigned RETRY_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lpm_en_i,
  input  logic lpm_ack_i,
  input  logic lpm_rwake_flag_i,
  input  logic host_resume_i,
  input  logic bus_reset_i,
  input  logic sw_wr_i,
  input  logic sw_wdata_i,
  output logic lpm_sus_o,
  output logic wake_grant_o,
  output logic wake_pulse_o
);
  lpm_evt_t evt;
  logic tmr_expire;
  logic wake_fire;

  assign evt.ack  = lpm_ack_i && lpm_en_i;
  assign evt.kill = host_resume_i || bus_reset_i;

  lpm_retry_timer #(.RETRY_CYCLES(RETRY_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (evt.ack),
    .cancel_i (evt.kill),
    .expire_o (tmr_expire)
  );

  lpm_wake_grant u_grant (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ack_i        (evt.ack),
    .rwake_flag_i (lpm_rwake_flag_i),
    .clear_i      (evt.kill || wake_fire),
    .grant_o      (wake_grant_o)
  );

  lpm_sus_ctrl u_sus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (lpm_en_i),
    .expire_i     (tmr_expire),
    .kill_i       (evt.kill),
    .sw_wr_i      (sw_wr_i),
    .sw_wdata_i   (sw_wdata_i),
    .grant_i      (wake_grant_o),
    .sus_o        (lpm_sus_o),
    .wake_fire_o  (wake_fire),
    .wake_pulse_o (wake_pulse_o)
  );
endmodule

// File: rtl/lpm_sleep_checker.sv
module lpm_sleep_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic lpm_en_i,
  input logic lpm_ack_i,
  input logic lpm_rwake_flag_i,
  input logic host_resume_i,
  input logic bus_reset_i,
  input logic sw_wr_i,
  input logic sw_wdata_i,
  input logic expire_i,
  input logic lpm_sus_o,
  input logic wake_grant_o,
  input logic wake_pulse_o
);
  assert_rise_after_expiry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lpm_sus_o) |-> $past(expire_i) && $past(lpm_en_i));

  assert_grant_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lpm_ack_i && lpm_en_i && lpm_rwake_flag_i && !host_resume_i && !bus_reset_i
    |=> wake_grant_o);

  assert_resume_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_resume_i && lpm_en_i |=> !lpm_sus_o && !wake_grant_o);

  assert_bus_reset_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i && lpm_en_i |=> !lpm_sus_o && !wake_grant_o);

  assert_wake_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |=> !wake_pulse_o);

  assert_wake_needs_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_pulse_o |-> $past(wake_grant_o) && $past(lpm_sus_o) && !lpm_sus_o && !wake_grant_o);

  assert_ignored_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_wr_i && (sw_wdata_i || !wake_grant_o || !lpm_sus_o) |=> !wake_pulse_o);

  assert_disabled_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpm_en_i |=> $stable(lpm_sus_o));

  assert_kill_beats_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_resume_i || bus_reset_i) |=> !wake_pulse_o);
endmodule

bind lpm_sleep_tracker lpm_sleep_checker u_lpm_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .lpm_en_i         (lpm_en_i),
  .lpm_ack_i        (lpm_ack_i),
  .lpm_rwake_flag_i (lpm_rwake_flag_i),
  .host_resume_i    (host_resume_i),
  .bus_reset_i      (bus_reset_i),
  .sw_wr_i          (sw_wr_i),
  .sw_wdata_i       (sw_wdata_i),
  .expire_i         (tmr_expire),
  .lpm_sus_o        (lpm_sus_o),
  .wake_grant_o     (wake_grant_o),
  .wake_pulse_o     (wake_pulse_o)
);

// File: tb/lpm_sleep_tracker_bench.sv
module lpm_sleep_tracker_bench;
  localparam int RT = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic lpm_en_i = 1'b0, lpm_ack_i = 1'b0, lpm_rwake_flag_i = 1'b0;
  logic host_resume_i = 1'b0, bus_reset_i = 1'b0, sw_wr_i = 1'b0, sw_wdata_i = 1'b0;
  logic lpm_sus_o, wake_grant_o, wake_pulse_o;

  always #5 clk_i = ~clk_i;

  lpm_sleep_tracker #(.RETRY_CYCLES(RT)) u_lpm_sleep_tracker (
    .clk_i, .rst_ni, .lpm_en_i, .lpm_ack_i, .lpm_rwake_flag_i,
    .host_resume_i, .bus_reset_i, .sw_wr_i, .sw_wdata_i,
    .lpm_sus_o, .wake_grant_o, .wake_pulse_o
  );

  typedef struct {
    int    cyc;
    logic  sus;
    logic  grant;
    logic  pulse;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  // monitor: samples 2 ns after each rising edge
  initial forever begin
    @(posedge clk_i);
    #2;
    cyc++;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      exp_t it;
      it = sb_q.pop_front();
      n_run++;
      if (it.cyc < cyc || lpm_sus_o !== it.sus || wake_grant_o !== it.grant ||
          wake_pulse_o !== it.pulse) begin
        n_fail++;
        $display("FAIL %s cyc %0d: got sus=%b grant=%b pulse=%b, expected sus=%b grant=%b pulse=%b",
                 it.tag, it.cyc, lpm_sus_o, wake_grant_o, wake_pulse_o,
                 it.sus, it.grant, it.pulse);
      end
    end
  end

  task automatic expect_out(int dly, logic s, logic g, logic p, string tag);
    exp_t it;
    it.cyc = cyc + dly; it.sus = s; it.grant = g; it.pulse = p; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_ack(logic flag);
    lpm_ack_i = 1'b1; lpm_rwake_flag_i = flag;
    tick(1);
    lpm_ack_i = 1'b0; lpm_rwake_flag_i = 1'b0;
  endtask

  task automatic send_write(logic v);
    sw_wr_i = 1'b1; sw_wdata_i = v;
    tick(1);
    sw_wr_i = 1'b0; sw_wdata_i = 1'b0;
  endtask

  task automatic send_resume();
    host_resume_i = 1'b1; tick(1); host_resume_i = 1'b0;
  endtask

  task automatic send_bus_reset();
    bus_reset_i = 1'b1; tick(1); bus_reset_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: got no completion, expected run to end");
    finish_run();
  end

  initial begin
    tick(3);
    rst_ni = 1'b1; lpm_en_i = 1'b1;
    expect_out(1, 0, 0, 0, "R1");
    tick(2);

    // R2/R4: acknowledge with wake flag, suspend after exactly RT edges
    expect_out(1, 0, 1, 0, "R4");
    expect_out(RT, 0, 1, 0, "R2");
    expect_out(RT + 1, 1, 1, 0, "R2");
    send_ack(1'b1); tick(RT + 2);

    // R8: writing one has no effect
    expect_out(1, 1, 1, 0, "R8");
    send_write(1'b1); tick(2);

    // R7: write zero with grant -> single strobe, both bits clear
    expect_out(1, 0, 0, 1, "R7");
    expect_out(2, 0, 0, 0, "R7");
    send_write(1'b0); tick(2);

    // R4: flag 0 leaves grant clear; R8: write zero without grant ignored
    expect_out(RT + 1, 1, 0, 0, "R4");
    send_ack(1'b0); tick(RT + 2);
    expect_out(1, 1, 0, 0, "R8");
    expect_out(2, 1, 0, 0, "R8");
    send_write(1'b0); tick(2);

    // R5: host resume clears suspend
    expect_out(1, 0, 0, 0, "R5");
    send_resume(); tick(2);

    // R5: resume during wait cancels it and drops grant
    send_ack(1'b1); tick(2);
    expect_out(1, 0, 0, 0, "R5");
    expect_out(RT + 1, 0, 0, 0, "R5");
    send_resume(); tick(RT + 2);

    // R6: bus reset during wait cancels it
    send_ack(1'b0); tick(2);
    expect_out(RT + 1, 0, 0, 0, "R6");
    send_bus_reset(); tick(RT + 2);

    // R6: bus reset clears suspend and grant
    expect_out(RT + 1, 1, 1, 0, "R2");
    send_ack(1'b1); tick(RT + 2);
    expect_out(1, 0, 0, 0, "R6");
    send_bus_reset(); tick(2);

    // R3: second acknowledge restarts the wait
    send_ack(1'b0); tick(2);
    expect_out(RT - 2, 0, 0, 0, "R3");
    expect_out(RT, 0, 0, 0, "R3");
    expect_out(RT + 1, 1, 0, 0, "R3");
    send_ack(1'b0); tick(RT + 2);

    // R9: disabled -> suspend frozen against resume, acks ignored
    lpm_en_i = 1'b0;
    expect_out(1, 1, 0, 0, "R9");
    send_resume(); tick(1);
    expect_out(1, 1, 0, 0, "R9");
    expect_out(RT + 2, 1, 0, 0, "R9");
    send_ack(1'b1); tick(RT + 3);
    lpm_en_i = 1'b1;
    expect_out(1, 0, 0, 0, "R5");
    send_resume(); tick(2);

    // R10: resume on the exact expiry edge wins
    send_ack(1'b1);
    tick(RT - 1);
    expect_out(1, 0, 0, 0, "R10");
    expect_out(2, 0, 0, 0, "R10");
    send_resume(); tick(3);

    // R10: bus reset with a valid wake write -> no strobe
    expect_out(RT + 1, 1, 1, 0, "R2");
    send_ack(1'b1); tick(RT + 2);
    bus_reset_i = 1'b1;
    expect_out(1, 0, 0, 0, "R10");
    expect_out(2, 0, 0, 0, "R10");
    send_write(1'b0);
    bus_reset_i = 1'b0;
    tick(3);

    if (sb_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule